// File: doc/BRIEF.md
# Serial programming slave interface

This block is the target end of a four-byte serial programming link for an on-chip memory. The memory holds word-organised flash pages and a byte-wide EEPROM. An external programmer drives a serial clock, a data line and a programming reset pin. The block samples incoming bits on rising serial clock edges and shifts its response out on falling edges. It groups the bits into four-byte instructions and turns each instruction into single-cycle strobes towards the memory arrays. The arrays themselves are outside the block.

The serial clock is treated as ordinary data. It is synchronised into the system clock domain and its edges are detected there, so each serial clock phase must span several system clocks. No command except programming-enable has any effect until a programming-enable has been received in sync. While the third byte of any instruction is being clocked in, the block returns the second byte, which proves framing to the programmer. A pulse on the programming reset pin drops the sync state and restarts byte framing.

An internal busy timer starts on every flash page write, EEPROM write and chip erase. While it runs, commands that change memory are ignored, and a poll command reports its state.

Top module: `spi_prog_slave`

## Requirements
- R1: `miso_o` changes only in response to a falling serial clock edge, a programming reset, or the start of a new byte. Bits are shifted out MSB first. The response byte is valid on `miso_o` before the first rising edge of that byte.
- R2: Every instruction is four bytes, MSB first. The response during byte 2 is byte 1 as received, and the response during byte 3 is byte 2 as received. This holds whether or not the instruction is recognised.
- R3: Until a programming-enable (0xAC 0x53 x x) has completed, no memory strobe is issued. During this time the response during byte 4 is byte 3 as received.
- R4: `sync_o` is 0 after reset. It becomes 1 at the end of a programming-enable instruction. A programming-enable with a wrong second byte leaves it at 0.
- R5: Load low (0x40 hh aa dd) writes dd into page-buffer word aa[6:0] with `word_hi_o`=0. Load high (0x48 hh aa dd) writes with `word_hi_o`=1, but only if a load low has been made to the same word since the last high load, page write or erase. Otherwise the load high is ignored.
- R6: Extended address (0x4D xx ee xx) stores ee. The stored value is kept until the next extended address command. Page write (0x4C hh aa xx) issues `page_wr_o` with `mem_addr_o` = {ee, hh, aa}. Flash reads use the same {ee, hh, aa} address.
- R7: EEPROM write (0xC0 hh aa dd) issues `ee_we_o` with `mem_addr_o` = {0x00, hh, aa} and `mem_wdata_o` = dd. It needs no erase beforehand.
- R8: Chip erase (0xAC 0x80 x x) issues `erase_o`. After it, every flash word and every EEPROM byte reads 0xFF.
- R9: Flash read low (0x20), flash read high (0x28) and EEPROM read (0xA0) pulse `fl_rd_o` or `ee_rd_o` after byte 3. The addressed byte is returned as byte 4.
- R10: Busy poll (0xF0 x x x) returns {7'b0, busy} as byte 4. `busy_o` rises only after a page write, EEPROM write or erase strobe.
- R11: While `busy_o` is 1, page-buffer loads, page writes, EEPROM writes and erases are ignored. At most one memory-changing strobe is active in any cycle.
- R12: A pulse on `prst_i` clears `sync_o` and the bit and byte counters. After the pulse, the next bit starts byte 1 of a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the programmer |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| prst_i | input | 1 | Programming reset pin, active high |
| sync_o | output | 1 | Programming enabled and in sync |
| busy_o | output | 1 | Write operation in progress |
| mem_addr_o | output | 24 | Memory address {extended, high, low} |
| mem_wdata_o | output | 8 | Write data |
| word_hi_o | output | 1 | High byte of a flash word selected |
| pbuf_we_o | output | 1 | Page-buffer load strobe |
| page_wr_o | output | 1 | Flash page write strobe |
| ee_we_o | output | 1 | EEPROM byte write strobe |
| erase_o | output | 1 | Chip erase strobe |
| fl_rd_o | output | 1 | Flash read strobe |
| ee_rd_o | output | 1 | EEPROM read strobe |
| mem_rdata_i | input | 8 | Read data, valid in the cycle of a read strobe |

## Verification
The assertions assume that each serial clock phase lasts well beyond the synchronizer depth, so a rising and a falling edge are never detected close together. They also assume that `mosi_i` is steady around each rising edge, that `prst_i` is held for several system clocks, and that `mem_rdata_i` follows a read strobe in the same cycle. The bench drives each serial clock phase for eight system clocks and changes data only while the serial clock is low. It holds the programming reset for four clocks and serves reads from a combinational memory model. The busy timer is long enough that a poll and a second write land inside it.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;
  localparam int INSTR_BYTES = 4;
  localparam logic [7:0] OP_EN_ER   = 8'hAC;
  localparam logic [7:0] SUB_EN     = 8'h53;
  localparam logic [7:0] SUB_ER     = 8'h80;
  localparam logic [7:0] OP_LD_LO   = 8'h40;
  localparam logic [7:0] OP_LD_HI   = 8'h48;
  localparam logic [7:0] OP_PG_WR   = 8'h4C;
  localparam logic [7:0] OP_EXT     = 8'h4D;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_FL_RDLO = 8'h20;
  localparam logic [7:0] OP_FL_RDHI = 8'h28;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;
  localparam logic [7:0] OP_POLL    = 8'hF0;
endpackage

// File: rtl/spi_prog_sync.sv
module spi_prog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic prst_i,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o,
  output logic prst_o
);
  logic [STAGES:0]   sck_q;
  logic [STAGES-1:0] mosi_q;
  logic [STAGES-1:0] prst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= '0;
      mosi_q <= '0;
      prst_q <= '0;
    end else begin
      sck_q  <= {sck_q[STAGES-1:0], sck_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      prst_q <= {prst_q[STAGES-2:0], prst_i};
    end
  end

  assign rise_o = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign fall_o = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign mosi_o = mosi_q[STAGES-1];
  assign prst_o = prst_q[STAGES-1];
endmodule

// File: rtl/spi_prog_shift.sv
module spi_prog_shift
  import spi_prog_pkg::*;
#(
  parameter int IW = $clog2(INSTR_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          din_i,
  input  logic          tx_load_i,
  input  logic [7:0]    tx_byte_i,
  output logic          miso_o,
  output logic          done_o,
  output logic [7:0]    byte_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] IDX_LAST = IW'(INSTR_BYTES - 1);

  logic [2:0]    bit_q;
  logic [7:0]    rx_q;
  logic [7:0]    tx_q;
  logic [IW-1:0] nidx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      nidx_q <= '0;
      done_o <= 1'b0;
      byte_o <= '0;
      idx_o  <= '0;
    end else if (clr_i) begin
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      nidx_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (rise_i) begin
        rx_q  <= {rx_q[6:0], din_i};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          done_o <= 1'b1;
          byte_o <= {rx_q[6:0], din_i};
          idx_o  <= nidx_q;
          nidx_q <= (nidx_q == IDX_LAST) ? '0 : nidx_q + 1'b1;
        end
      end
      // falling edge after the 8th bit leaves the freshly loaded MSB in place
      if (tx_load_i) tx_q <= tx_byte_i;
      else if (fall_i && bit_q != 3'd0) tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  assign miso_o = tx_q[7];

  // R1
  miso_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !tx_load_i && !clr_i) |=> $stable(miso_o));

  // R2
  byte_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rise_i));
endmodule

// File: rtl/spi_prog_ctrl.sv
module spi_prog_ctrl
  import spi_prog_pkg::*;
#(
  parameter int PAGE_WORDS = 128,
  parameter int FLASH_WAIT = 3000,
  parameter int EE_WAIT    = 3000,
  parameter int ERASE_WAIT = 6000,
  parameter int IW         = $clog2(INSTR_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          done_i,
  input  logic [7:0]    byte_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          tx_load_o,
  output logic [7:0]    tx_byte_o,
  output logic          sync_o,
  output logic          busy_o,
  output logic [23:0]   mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          word_hi_o,
  output logic          pbuf_we_o,
  output logic          page_wr_o,
  output logic          ee_we_o,
  output logic          erase_o,
  output logic          fl_rd_o,
  output logic          ee_rd_o
);
  localparam int WW = $clog2(PAGE_WORDS);
  localparam int MAXW = (FLASH_WAIT > EE_WAIT)
                      ? ((FLASH_WAIT > ERASE_WAIT) ? FLASH_WAIT : ERASE_WAIT)
                      : ((EE_WAIT > ERASE_WAIT) ? EE_WAIT : ERASE_WAIT);
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [IW-1:0] IDX_RD = IW'(INSTR_BYTES - 2);
  localparam logic [IW-1:0] IDX_EX = IW'(INSTR_BYTES - 1);

  logic [7:0]            b_q [INSTR_BYTES];
  logic [IW-1:0]         last_q;
  logic                  done_d;
  logic                  en_q;
  logic [7:0]            ext_q;
  logic [CW-1:0]         cnt_q;
  logic [PAGE_WORDS-1:0] lo_seen_q;

  logic [7:0]    op;
  logic          at_rd, at_ex, wr_ok, is_en, is_er, is_ee, is_poll;
  logic [WW-1:0] widx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < INSTR_BYTES; i++) b_q[i] <= '0;
      last_q <= '0;
      done_d <= 1'b0;
    end else begin
      done_d <= done_i & ~clr_i;
      if (done_i) begin
        b_q[idx_i] <= byte_i;
        last_q     <= idx_i;
      end
    end
  end

  assign op      = b_q[0];
  assign at_rd   = done_d && last_q == IDX_RD;
  assign at_ex   = done_d && last_q == IDX_EX;
  assign is_en   = op == OP_EN_ER && b_q[1] == SUB_EN;
  assign is_er   = op == OP_EN_ER && b_q[1] == SUB_ER;
  assign is_ee   = op == OP_EE_WR || op == OP_EE_RD;
  assign is_poll = op == OP_POLL;
  assign wr_ok   = at_ex && en_q && !busy_o;
  assign widx    = b_q[2][WW-1:0];

  assign pbuf_we_o = wr_ok && (op == OP_LD_LO || (op == OP_LD_HI && lo_seen_q[widx]));
  assign page_wr_o = wr_ok && op == OP_PG_WR;
  assign ee_we_o   = wr_ok && op == OP_EE_WR;
  assign erase_o   = wr_ok && is_er;
  assign fl_rd_o   = at_rd && en_q && (op == OP_FL_RDLO || op == OP_FL_RDHI);
  assign ee_rd_o   = at_rd && en_q && op == OP_EE_RD;

  assign mem_addr_o  = is_ee ? {8'h00, b_q[1], b_q[2]} : {ext_q, b_q[1], b_q[2]};
  assign mem_wdata_o = b_q[3];
  assign word_hi_o   = op[3];

  // response for the next byte: echo of the byte just taken, or read/poll data
  always_comb begin
    tx_byte_o = 8'h00;
    if (last_q == IDX_EX) tx_byte_o = 8'h00;
    else if (last_q == IDX_RD) begin
      if (fl_rd_o || ee_rd_o)    tx_byte_o = mem_rdata_i;
      else if (en_q && is_poll)  tx_byte_o = {7'b0, busy_o};
      else                       tx_byte_o = b_q[last_q];
    end else tx_byte_o = b_q[last_q];
  end
  assign tx_load_o = done_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ext_q <= '0;
    end else if (clr_i) begin
      en_q <= 1'b0;
    end else if (at_ex) begin
      if (is_en) en_q <= 1'b1;
      if (en_q && op == OP_EXT) ext_q <= b_q[2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (page_wr_o)      cnt_q <= CW'(FLASH_WAIT);
    else if (ee_we_o)        cnt_q <= CW'(EE_WAIT);
    else if (erase_o)        cnt_q <= CW'(ERASE_WAIT);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = cnt_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   lo_seen_q <= '0;
    else if (page_wr_o || erase_o) lo_seen_q <= '0;
    else if (pbuf_we_o)            lo_seen_q[widx] <= ~word_hi_o;
  end

  // R3
  no_early_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pbuf_we_o || page_wr_o || ee_we_o || erase_o) |-> sync_o);

  // R4
  sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(at_ex));

  // R10
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(page_wr_o || ee_we_o || erase_o));

  // R11
  no_write_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pbuf_we_o || page_wr_o || ee_we_o || erase_o) |-> !busy_o);

  // R11
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pbuf_we_o, page_wr_o, ee_we_o, erase_o}));

  assign sync_o = en_q;
endmodule

// File: rtl/spi_prog_slave.sv
module spi_prog_slave
  import spi_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_WORDS  = 128,
  parameter int FLASH_WAIT  = 3000,
  parameter int EE_WAIT     = 3000,
  parameter int ERASE_WAIT  = 6000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        mosi_i,
  output logic        miso_o,
  input  logic        prst_i,
  output logic        sync_o,
  output logic        busy_o,
  output logic [23:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        word_hi_o,
  output logic        pbuf_we_o,
  output logic        page_wr_o,
  output logic        ee_we_o,
  output logic        erase_o,
  output logic        fl_rd_o,
  output logic        ee_rd_o,
  input  logic [7:0]  mem_rdata_i
);
  localparam int IW = $clog2(INSTR_BYTES);

  logic          rise, fall, din, clr;
  logic          done, tx_load;
  logic [7:0]    rx_byte, tx_byte;
  logic [IW-1:0] idx;

  spi_prog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .mosi_i (mosi_i),
    .prst_i (prst_i),
    .rise_o (rise),
    .fall_o (fall),
    .mosi_o (din),
    .prst_o (clr)
  );

  spi_prog_shift #(.IW(IW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .rise_i    (rise),
    .fall_i    (fall),
    .din_i     (din),
    .tx_load_i (tx_load),
    .tx_byte_i (tx_byte),
    .miso_o    (miso_o),
    .done_o    (done),
    .byte_o    (rx_byte),
    .idx_o     (idx)
  );

  spi_prog_ctrl #(
    .PAGE_WORDS (PAGE_WORDS),
    .FLASH_WAIT (FLASH_WAIT),
    .EE_WAIT    (EE_WAIT),
    .ERASE_WAIT (ERASE_WAIT),
    .IW         (IW)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .done_i      (done),
    .byte_i      (rx_byte),
    .idx_i       (idx),
    .mem_rdata_i (mem_rdata_i),
    .tx_load_o   (tx_load),
    .tx_byte_o   (tx_byte),
    .sync_o      (sync_o),
    .busy_o      (busy_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .word_hi_o   (word_hi_o),
    .pbuf_we_o   (pbuf_we_o),
    .page_wr_o   (page_wr_o),
    .ee_we_o     (ee_we_o),
    .erase_o     (erase_o),
    .fl_rd_o     (fl_rd_o),
    .ee_rd_o     (ee_rd_o)
  );
endmodule

// File: tb/spi_prog_slave_test.sv
module spi_prog_slave_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, prst = 1'b0;
  logic miso, sync, busy, word_hi, pbuf_we, page_wr, ee_we, erase, fl_rd, ee_rd;
  logic [23:0] addr;
  logic [7:0]  wdata, rdata;

  int n_chk = 0, n_fail = 0, n_wr = 0, n_pg = 0;
  logic [23:0] last_pg = '0;

  always #4 clk = ~clk;

  spi_prog_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .mosi_i(mosi), .miso_o(miso),
    .prst_i(prst), .sync_o(sync), .busy_o(busy), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .word_hi_o(word_hi), .pbuf_we_o(pbuf_we),
    .page_wr_o(page_wr), .ee_we_o(ee_we), .erase_o(erase), .fl_rd_o(fl_rd),
    .ee_rd_o(ee_rd), .mem_rdata_i(rdata)
  );

  // memory model
  logic [7:0] ee_m [256];
  logic [7:0] fl_lo [1024];
  logic [7:0] fl_hi [1024];
  logic [7:0] pb_lo [128];
  logic [7:0] pb_hi [128];

  initial begin
    for (int i = 0; i < 256; i++) ee_m[i] = 8'hFF;
    for (int i = 0; i < 1024; i++) begin fl_lo[i] = 8'hFF; fl_hi[i] = 8'hFF; end
    for (int i = 0; i < 128; i++) begin pb_lo[i] = 8'hFF; pb_hi[i] = 8'hFF; end
  end

  always @(posedge clk) begin
    if (pbuf_we || page_wr || ee_we || erase) n_wr <= n_wr + 1;
    if (erase) begin
      for (int i = 0; i < 256; i++) ee_m[i] <= 8'hFF;
      for (int i = 0; i < 1024; i++) begin fl_lo[i] <= 8'hFF; fl_hi[i] <= 8'hFF; end
    end
    if (ee_we) ee_m[addr[7:0]] <= wdata;
    if (pbuf_we) begin
      if (word_hi) pb_hi[addr[6:0]] <= wdata;
      else         pb_lo[addr[6:0]] <= wdata;
    end
    if (page_wr) begin
      n_pg    <= n_pg + 1;
      last_pg <= addr;
      for (int i = 0; i < 128; i++) begin
        fl_lo[{addr[16], addr[8:7], 7'(i)}] <= pb_lo[i];
        fl_hi[{addr[16], addr[8:7], 7'(i)}] <= pb_hi[i];
        pb_lo[i] <= 8'hFF;
        pb_hi[i] <= 8'hFF;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (ee_rd) rdata = ee_m[addr[7:0]];
    else if (fl_rd) rdata = word_hi ? fl_hi[{addr[16], addr[8:0]}] : fl_lo[{addr[16], addr[8:0]}];
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] b0, b1, b2, b3, output logic [31:0] resp);
    logic [31:0] w;
    w = {b0, b1, b2, b3};
    for (int i = 31; i >= 0; i--) begin
      mosi = w[i];
      repeat (HALF) @(negedge clk);
      resp[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] b0, b1, b2, b3, exp;
    logic       chk, drain;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{8'hC0, 8'h00, 8'h10, 8'h5A, 8'h00, 1'b0, 1'b1, 8'd7},  // R7 ee write
    '{8'hA0, 8'h00, 8'h10, 8'h00, 8'h5A, 1'b1, 1'b0, 8'd9},  // R9 ee read
    '{8'hC0, 8'h00, 8'h11, 8'hA5, 8'h00, 1'b0, 1'b0, 8'd7},  // R7
    '{8'hF0, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, 8'd10}, // R10 busy=1
    '{8'hC0, 8'h00, 8'h12, 8'h33, 8'h00, 1'b0, 1'b1, 8'd11}, // R11 ignored
    '{8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'd10}, // R10 busy=0
    '{8'hA0, 8'h00, 8'h12, 8'h00, 8'hFF, 1'b1, 1'b0, 8'd11}, // R11
    '{8'hA0, 8'h00, 8'h11, 8'h00, 8'hA5, 1'b1, 1'b0, 8'd9},  // R9
    '{8'h40, 8'h00, 8'h05, 8'h11, 8'h00, 1'b0, 1'b0, 8'd5},  // R5 low
    '{8'h48, 8'h00, 8'h05, 8'h22, 8'h00, 1'b0, 1'b0, 8'd5},  // R5 high
    '{8'h48, 8'h00, 8'h06, 8'h44, 8'h00, 1'b0, 1'b0, 8'd5},  // R5 high w/o low
    '{8'h40, 8'h00, 8'h06, 8'h55, 8'h00, 1'b0, 1'b0, 8'd5},  // R5
    '{8'h4D, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 8'd6},  // R6 ext=1
    '{8'h4C, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'd6},  // R6 page write
    '{8'h20, 8'h00, 8'h05, 8'h00, 8'h11, 1'b1, 1'b0, 8'd9},  // R9 flash lo
    '{8'h28, 8'h00, 8'h05, 8'h00, 8'h22, 1'b1, 1'b0, 8'd5},  // R5
    '{8'h28, 8'h00, 8'h06, 8'h00, 8'hFF, 1'b1, 1'b0, 8'd5},  // R5 ignored high
    '{8'h20, 8'h00, 8'h06, 8'h00, 8'h55, 1'b1, 1'b0, 8'd5},  // R5
    '{8'h4D, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'd6},  // R6 ext=0
    '{8'h20, 8'h00, 8'h05, 8'h00, 8'hFF, 1'b1, 1'b0, 8'd6},  // R6
    '{8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'd8},  // R8 erase
    '{8'hA0, 8'h00, 8'h10, 8'h00, 8'hFF, 1'b1, 1'b0, 8'd8},  // R8
    '{8'h4D, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 8'd8},  // R8
    '{8'h20, 8'h00, 8'h05, 8'h00, 8'hFF, 1'b1, 1'b0, 8'd8}   // R8
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    chk(sync, 0, "R4 reset sync");
    chk(busy, 0, "R10 reset busy");
    chk(miso, 0, "R1 reset miso");

    // R3 commands before enable
    xfer(8'hC0, 8'h00, 8'h20, 8'h77, r);
    xfer(8'hA0, 8'h00, 8'h20, 8'h00, r);
    chk(r[7:0], 8'h20, "R3 echo before enable");
    chk(n_wr, 0, "R3 no strobes before enable");

    // R4 wrong enable
    xfer(8'hAC, 8'h52, 8'h00, 8'h00, r);
    chk(r[15:8], 8'h52, "R2 echo wrong enable");
    chk(sync, 0, "R4 wrong enable");

    xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk(r[15:8], 8'h53, "R2 enable echo");
    chk(r[23:16], 8'hAC, "R2 byte2 echo");
    chk(sync, 1, "R4 enable");

    xfer(8'hA0, 8'h00, 8'h20, 8'h00, r);
    chk(r[7:0], 8'hFF, "R3 write before enable dropped");

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v].b0, VEC[v].b1, VEC[v].b2, VEC[v].b3, r);
      chk(r[15:8], VEC[v].b1, $sformatf("R2 vector %0d", v));
      if (VEC[v].chk) chk(r[7:0], VEC[v].exp, $sformatf("R%0d vector %0d", VEC[v].rq, v));
      if (VEC[v].drain) drain();
    end

    chk(n_pg, 1, "R6 page write count");
    chk(last_pg, 24'h010000, "R6 page address");

    // R12 partial byte then programming reset
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    prst = 1'b1;
    repeat (4) @(negedge clk);
    prst = 1'b0;
    repeat (6) @(negedge clk);
    chk(sync, 0, "R12 sync cleared");
    chk(miso, 0, "R12 miso cleared");
    xfer(8'hA0, 8'h00, 8'h11, 8'h00, r);
    chk(r[15:8], 8'h00, "R12 framing restart");
    chk(r[7:0], 8'h11, "R12 read ignored after reset");
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk(r[15:8], 8'h53, "R12 resync echo");
    xfer(8'hA0, 8'h00, 8'h11, 8'h00, r);
    chk(r[7:0], 8'hFF, "R12 read after resync");

    report();
  end
endmodule